// File: doc/BRIEF.md
# Diminished-1 Four-Operand Carry-Save Compressor Modulo 2^n+1

This block reduces four operands, each held in diminished-1 code modulo 2^n+1 (a value V in the range 1 to 2^n is stored as the n-bit word V-1), to a pair of n-bit words in the same code: a sum word and a carry word. The two outputs together carry the modular total of the four inputs. A later carry-propagate adder, outside this block, resolves the pair into one residue. The block serves as the adder-free reduction step of number-theoretic transform butterflies and code converters, where many such additions are chained and only the last stage pays for carry propagation.

The datapath is a row of one-bit 4-2 cells. Each cell forms the XOR and XNOR of its operand pairs first and uses them as multiplexer selects, which keeps the slow path short. The transfer bit leaving the top cell and the carry bit shifted out of the top position both return to bit 0 complemented. Because 2^n is congruent to -1 modulo 2^n+1, this end-around inversion keeps the result in range, and the constant it injects supplies the diminished-1 offset correction. No carry ripples across the word. The interface is purely combinational and has no clock or handshake. Since every n-bit code stands for a nonzero value, the true value zero cannot be presented, and callers must keep it away from this block.

Top module: `dim1_csa42`

## Requirements
- R1: For every input combination, ((sum_vec+1)+(carry_vec+1)) mod (2^WIDTH+1) equals the sum of (operand+1) over the four operands, taken mod (2^WIDTH+1).
- R2: Let the transfer bit into position i be the majority of opnd_w, opnd_x and opnd_y at position i-1 for i>=1, and the complement of their majority at position WIDTH-1 for i=0. Then sum_vec bit i equals the XOR of the four operand bits at i and that transfer bit.
- R3: For i>=1, carry_vec bit i equals the cell carry of position i-1. The cell carry at position k is the transfer bit into k when the XOR of the four operand bits at k is 1, and opnd_z bit k otherwise.
- R4: carry_vec bit 0 equals the complement of the cell carry at position WIDTH-1.
- R5: Exchanging opnd_w and opnd_z leaves the modular value of the output pair unchanged.
- R6: With all four operand codes zero (each value 1), both sum_vec and carry_vec equal 1.
- R7: With all four operand codes all-ones (each value 2^WIDTH), both sum_vec and carry_vec equal all-ones with bit 0 cleared.
- R8: When all operand bits are known, no output bit is unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_w | input | WIDTH | First operand, diminished-1 code |
| opnd_x | input | WIDTH | Second operand, diminished-1 code |
| opnd_y | input | WIDTH | Third operand, diminished-1 code |
| opnd_z | input | WIDTH | Fourth operand, diminished-1 code; steers the cell carry |
| sum_vec | output | WIDTH | Sum word, diminished-1 code |
| carry_vec | output | WIDTH | Carry word, shifted one place with inverted end-around bit, diminished-1 code |

## Verification
The bound checker evaluates the modular equivalence of R1, the fixed results for the all-zero and all-ones patterns (R6, R7) and the absence of unknown outputs (R8) on every change of the operands. The exact bit placement of both output words (R2, R3, R4), including the inverted wrap into bit 0, is shown only by the bench, which compares each bit with its own model over directed and random patterns. The operand-swap invariance of R5 also needs paired scenarios.

// File: rtl/dim1_pkg.sv
package dim1_pkg;

  // Result of one 4-2 cell: sum bit, carry bit (weight 2, into the carry
  // word) and the transfer bit handed to the next more significant cell.
  typedef struct packed {
    logic sum;
    logic carry;
    logic xfer;
  } cell42_t;

  // Two-input selector used as the basic element of the cell.
  function automatic logic pick(input logic sel, input logic when0,
                                input logic when1);
    return sel ? when1 : when0;
  endfunction

endpackage

// File: rtl/dim1_cell42.sv
module dim1_cell42
  import dim1_pkg::*;
(
  input  logic    in_a,
  input  logic    in_b,
  input  logic    in_c,
  input  logic    in_d,
  input  logic    xfer_in,
  output cell42_t res
);

  logic ab_x, ab_n, cd_x, cd_n, all_x, all_n;

  // Pair differences and equalities are both formed early; they later
  // drive selector inputs instead of feeding a second adder stage.
  always_comb begin
    ab_x  = in_a ^ in_b;
    ab_n  = in_a ~^ in_b;
    cd_x  = in_c ^ in_d;
    cd_n  = in_c ~^ in_d;
    all_x = pick(ab_x, cd_x, cd_n);
    all_n = pick(ab_x, cd_n, cd_x);
  end

  // Transfer does not depend on xfer_in, so no ripple forms across the row.
  always_comb begin
    res.xfer  = pick(ab_n, in_c, in_a);
    res.sum   = pick(xfer_in, all_x, all_n);
    res.carry = pick(all_n, xfer_in, in_d);
  end

endmodule

// File: rtl/dim1_row42.sv
module dim1_row42
  import dim1_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] row_a,
  input  logic [WIDTH-1:0] row_b,
  input  logic [WIDTH-1:0] row_c,
  input  logic [WIDTH-1:0] row_d,
  output logic [WIDTH-1:0] row_sum,
  output logic [WIDTH-1:0] row_carry
);

  localparam int TOP = WIDTH - 1;

  cell42_t          cells [WIDTH];
  logic [WIDTH-1:0] xfer_out;
  logic [WIDTH-1:0] xfer_in;

  // Transfer chain: each position takes its lower neighbour's transfer,
  // position 0 takes the top transfer complemented (2^n == -1).
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_link
      if (i == 0) begin : g_wrap
        assign xfer_in[i] = ~xfer_out[TOP];
      end else begin : g_pass
        assign xfer_in[i] = xfer_out[i-1];
      end
    end
  endgenerate

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      dim1_cell42 u_cell (
        .in_a   (row_a[i]),
        .in_b   (row_b[i]),
        .in_c   (row_c[i]),
        .in_d   (row_d[i]),
        .xfer_in(xfer_in[i]),
        .res    (cells[i])
      );
      assign xfer_out[i]  = cells[i].xfer;
      assign row_sum[i]   = cells[i].sum;
      assign row_carry[i] = cells[i].carry;
    end
  endgenerate

endmodule

// File: rtl/dim1_csa42.sv
module dim1_csa42 #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_w,
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [WIDTH-1:0] opnd_z,
  output logic [WIDTH-1:0] sum_vec,
  output logic [WIDTH-1:0] carry_vec
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] cell_carry;

  dim1_row42 #(.WIDTH(WIDTH)) u_row (
    .row_a    (opnd_w),
    .row_b    (opnd_x),
    .row_c    (opnd_y),
    .row_d    (opnd_z),
    .row_sum  (sum_vec),
    .row_carry(cell_carry)
  );

  // Carry word is the cell carries moved up one place; the bit pushed out
  // of the top returns complemented at position 0, adding the offset.
  generate
    if (WIDTH > 1) begin : g_shift
      assign carry_vec = {cell_carry[TOP-1:0], ~cell_carry[TOP]};
    end else begin : g_single
      assign carry_vec = ~cell_carry;
    end
  endgenerate

endmodule

// File: rtl/dim1_csa42_chk.sv
module dim1_csa42_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opnd_w,
  input logic [WIDTH-1:0] opnd_x,
  input logic [WIDTH-1:0] opnd_y,
  input logic [WIDTH-1:0] opnd_z,
  input logic [WIDTH-1:0] sum_vec,
  input logic [WIDTH-1:0] carry_vec
);

  localparam longint MODULUS = (longint'(1) << WIDTH) + 1;
  localparam logic [WIDTH-1:0] CODE_ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] CODE_FULL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CODE_FE   = CODE_FULL << 1;

  longint want_res;
  longint have_res;

  always_comb begin
    want_res = (longint'(opnd_w) + longint'(opnd_x) + longint'(opnd_y)
                + longint'(opnd_z) + 4) % MODULUS;
    have_res = (longint'(sum_vec) + longint'(carry_vec) + 2) % MODULUS;

    assert_mod_sum_R1: assert (have_res == want_res)
      else $error("R1 modular total %0d expected %0d", have_res, want_res);

    assert_all_zero_R6: assert ((|{opnd_w, opnd_x, opnd_y, opnd_z}) ||
                                (sum_vec == CODE_ONE && carry_vec == CODE_ONE))
      else $error("R6 zero codes gave %h/%h", sum_vec, carry_vec);

    assert_all_ones_R7: assert (!(&{opnd_w, opnd_x, opnd_y, opnd_z}) ||
                                (sum_vec == CODE_FE && carry_vec == CODE_FE))
      else $error("R7 full codes gave %h/%h", sum_vec, carry_vec);

    assert_known_R8: assert ($isunknown({opnd_w, opnd_x, opnd_y, opnd_z}) ||
                             !$isunknown({sum_vec, carry_vec}))
      else $error("R8 unknown output");
  end

endmodule

bind dim1_csa42 dim1_csa42_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_w   (opnd_w),
  .opnd_x   (opnd_x),
  .opnd_y   (opnd_y),
  .opnd_z   (opnd_z),
  .sum_vec  (sum_vec),
  .carry_vec(carry_vec)
);

// File: tb/dim1_csa42_test.sv
`timescale 1ns/1ps
module dim1_csa42_test;

  localparam int W   = 8;
  localparam int MOD = (1 << W) + 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] w_in, x_in, y_in, z_in;
  logic [W-1:0] s_out, c_out;
  int           n_checks = 0;
  int           n_errors = 0;

  always #2.5 clk = ~clk;

  dim1_csa42 #(.WIDTH(W)) uut (
    .opnd_w   (w_in),
    .opnd_x   (x_in),
    .opnd_y   (y_in),
    .opnd_z   (z_in),
    .sum_vec  (s_out),
    .carry_vec(c_out)
  );

  function automatic logic maj3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [W-1:0] xfer_model(logic [W-1:0] w, logic [W-1:0] x,
                                              logic [W-1:0] y);
    logic [W-1:0] t;
    t[0] = ~maj3(w[W-1], x[W-1], y[W-1]);
    for (int i = 1; i < W; i++) t[i] = maj3(w[i-1], x[i-1], y[i-1]);
    return t;
  endfunction

  function automatic logic [W-1:0] cellc_model(logic [W-1:0] w, logic [W-1:0] x,
                                               logic [W-1:0] y, logic [W-1:0] z);
    logic [W-1:0] t, k;
    t = xfer_model(w, x, y);
    for (int i = 0; i < W; i++) k[i] = (w[i] ^ x[i] ^ y[i] ^ z[i]) ? t[i] : z[i];
    return k;
  endfunction

  function automatic int ref_total(logic [W-1:0] w, logic [W-1:0] x,
                                   logic [W-1:0] y, logic [W-1:0] z);
    return (int'(w) + int'(x) + int'(y) + int'(z) + 4) % MOD;
  endfunction

  function automatic int pair_total(logic [W-1:0] s, logic [W-1:0] c);
    return (int'(s) + int'(c) + 2) % MOD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] w, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [W-1:0] z);
    @(posedge clk);
    w_in = w; x_in = x; y_in = y; z_in = z;
    @(negedge clk);
  endtask

  // Full comparison of one pattern against R1..R4 and R8.
  task automatic check_all(input logic [W-1:0] w, input logic [W-1:0] x,
                           input logic [W-1:0] y, input logic [W-1:0] z);
    logic [W-1:0] t, k, es;
    apply(w, x, y, z);
    t  = xfer_model(w, x, y);
    k  = cellc_model(w, x, y, z);
    es = w ^ x ^ y ^ z ^ t;
    check(!$isunknown({s_out, c_out}), "R8", int'(s_out), int'(es));
    check(pair_total(s_out, c_out) == ref_total(w, x, y, z), "R1",
          pair_total(s_out, c_out), ref_total(w, x, y, z));
    check(s_out == es, "R2", int'(s_out), int'(es));
    check(c_out[W-1:1] == k[W-2:0], "R3", int'(c_out[W-1:1]), int'(k[W-2:0]));
    check(c_out[0] == ~k[W-1], "R4", int'(c_out[0]), int'(~k[W-1]));
  endtask

  task automatic check_swap(input logic [W-1:0] w, input logic [W-1:0] x,
                            input logic [W-1:0] y, input logic [W-1:0] z);
    int first;
    apply(w, x, y, z);
    first = pair_total(s_out, c_out);
    apply(z, x, y, w);
    check(pair_total(s_out, c_out) == first, "R5", pair_total(s_out, c_out), first);
  endtask

  initial begin
    w_in = '0; x_in = '0; y_in = '0; z_in = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: operands held at code zero, R6 outputs expected.
    check(s_out == 8'h01 && c_out == 8'h01, "R6 reset", int'({s_out, c_out}), 16'h0101);

    apply(8'h00, 8'h00, 8'h00, 8'h00);
    check(s_out == 8'h01, "R6 sum", int'(s_out), 8'h01);
    check(c_out == 8'h01, "R6 carry", int'(c_out), 8'h01);

    apply(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    check(s_out == 8'hFE, "R7 sum", int'(s_out), 8'hFE);
    check(c_out == 8'hFE, "R7 carry", int'(c_out), 8'hFE);

    // Top-bit majority wraps complemented into bit 0 (R2, R4).
    apply(8'h80, 8'h80, 8'h80, 8'h00);
    check(s_out == 8'h80, "R2 wrap", int'(s_out), 8'h80);
    check(c_out == 8'h01, "R4 wrap", int'(c_out), 8'h01);

    check_all(8'h80, 8'h80, 8'h80, 8'h80);
    check_all(8'h7F, 8'h00, 8'hFF, 8'h01);
    check_all(8'hAA, 8'h55, 8'hAA, 8'h55);
    check_all(8'hFF, 8'h00, 8'h00, 8'hFF);
    check_swap(8'h80, 8'h01, 8'h7F, 8'hFE);

    for (int n = 0; n < 3000; n++) begin
      check_all(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
      if (n % 10 == 0)
        check_swap(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule